// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block runs the memory side of subroutine linkage for a small processor core. Given one operation code and a snapshot of the relevant register values, it steps through one or two 32-bit word accesses on a request/acknowledge memory port. It then hands back the new register values and, for calls and returns, the new program counter. It handles five operations: a call to an absolute address, a call through a register, a return, a push and a pop.

A call builds a frame. An 8-byte slot below the stack pointer receives the return address in its lower word, and the word above it is left free for a static-chain value. The old frame pointer (register 0) is stored just below that slot. Both the frame pointer and the stack pointer (register 1) then take the address of the saved frame pointer, and control passes to the target. A return undoes these steps in reverse order. Push and pop work on any register chosen as the stack base. The register file, the memory and interrupt entry belong to neighbouring blocks.

Top module: `stack_frame_seq`

## Requirements
- R1: Out of reset, and whenever the sequencer is idle, mem_req, wr0_en, wr1_en, pc_we and done are all low.
- R2: Op code 0 (absolute call) with stack pointer S and frame pointer F first writes pc_in+6 to address S-8, then writes F to address S-12. In the write-back cycle it drives wr0 (index 0) = S-12, wr1 (index 1) = S-12 and pc_out = target.
- R3: Op code 1 (register call) behaves as R2, except that the stored return address is pc_in+2. The jump target is the register value the caller supplies on target.
- R4: Op code 2 (return) with frame pointer F first reads address F, then reads address F+4. In the write-back cycle it drives wr0 (index 0) = first word read, wr1 (index 1) = F+12 and pc_out = second word read.
- R5: Op code 3 (push) with stack base value B writes push_data to address B-4. It then drives wr1 = B-4 to index stk_idx and leaves wr0 and pc_we low.
- R6: Op code 4 (pop) with stack base value B reads address B. It drives wr0 = word read to index dst_idx and wr1 = B+4 to index stk_idx. When dst_idx equals stk_idx, only wr0 is driven.
- R7: A request holds mem_req, mem_addr, mem_we and mem_wdata steady until mem_ack. The sequencer waits for any number of cycles, and every access is counted complete on the cycle in which mem_req and mem_ack are both high.
- R8: A base value that is not a multiple of 4 at start (stack pointer for calls, frame pointer for return, stack base for push and pop) makes no access and no write-back. The next cycle then gives done and err together.
- R9: All register and PC write-backs of an operation happen in a single cycle. done is high for exactly the cycle after it, and err stays low on success.
- R10: start is ignored while an operation is in progress, and no extra access or done follows.
- R11: Op codes 5 to 7 are rejected in the same way as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code (see R2 to R6, R11) |
| stk_idx | input | 4 | Register used as stack base for push and pop |
| dst_idx | input | 4 | Destination register for pop |
| target | input | 32 | Call destination address |
| pc_in | input | 32 | Address of the call operation |
| fp_in | input | 32 | Frame pointer value |
| sp_in | input | 32 | Stack pointer value |
| stk_in | input | 32 | Value of the stack base register for push and pop |
| push_data | input | 32 | Word stored by push |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| wr0_en | output | 1 | Write-back port 0 enable |
| wr0_idx | output | 4 | Write-back port 0 register index |
| wr0_data | output | 32 | Write-back port 0 value |
| wr1_en | output | 1 | Write-back port 1 enable |
| wr1_idx | output | 4 | Write-back port 1 register index |
| wr1_data | output | 32 | Write-back port 1 value |
| pc_we | output | 1 | Program counter update |
| pc_out | output | 32 | New program counter |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected operation, valid with done |

## Verification
The assertions assume that mem_ack is only ever high while mem_req is high, and that mem_rdata is valid in the acknowledge cycle. They also assume that start comes no earlier than the cycle after reset is released. The bench memory model acknowledges only a pending request, after a programmable number of wait cycles, and drops the acknowledge on the cycle after each one. The bench drives start from a single task, with one scenario in flight at a time. The only deliberate exception is the busy-poke test, where start is raised in the middle of an access, as R10 allows.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_CALL_ABS = 3'd0;
  localparam logic [OP_W-1:0] OP_CALL_REG = 3'd1;
  localparam logic [OP_W-1:0] OP_RETURN   = 3'd2;
  localparam logic [OP_W-1:0] OP_PUSH     = 3'd3;
  localparam logic [OP_W-1:0] OP_POP      = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC1,
    ST_ACC2,
    ST_WB,
    ST_DONE
  } seq_state_e;

  function automatic logic op_is_call(input logic [OP_W-1:0] o);
    return (o == OP_CALL_ABS) || (o == OP_CALL_REG);
  endfunction

  function automatic logic op_known(input logic [OP_W-1:0] o);
    return o <= OP_POP;
  endfunction
endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fault,
  input  logic two_acc,
  input  logic mem_ack,
  output logic accept,
  output logic busy,
  output logic st_acc1,
  output logic st_acc2,
  output logic st_wb,
  output logic done,
  output logic err
);
  seq_state_e state_q, state_d;
  logic two_q, err_q;

  assign busy    = (state_q != ST_IDLE);
  assign accept  = start && !busy;
  assign st_acc1 = (state_q == ST_ACC1);
  assign st_acc2 = (state_q == ST_ACC2);
  assign st_wb   = (state_q == ST_WB);
  assign done    = (state_q == ST_DONE);
  assign err     = done && err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = fault ? ST_DONE : ST_ACC1;
      ST_ACC1: if (mem_ack) state_d = two_q ? ST_ACC2 : ST_WB;
      ST_ACC2: if (mem_ack) state_d = ST_WB;
      ST_WB:   state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      two_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        two_q <= two_acc;
        err_q <= fault;
      end
    end
  end
endmodule

// File: rtl/frame_seq_dpath.sv
module frame_seq_dpath
  import frame_seq_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int IDX_W          = 4,
  parameter int FP_IDX         = 0,
  parameter int SP_IDX         = 1,
  parameter int WORD_BYTES     = 4,
  parameter int SLOT_BYTES     = 8,
  parameter int LONG_CALL_LEN  = 6,
  parameter int SHORT_CALL_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              st_acc1,
  input  logic              st_acc2,
  input  logic              st_wb,
  input  logic [OP_W-1:0]   op,
  input  logic [IDX_W-1:0]  stk_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [DATA_W-1:0] target,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] fp_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] stk_in,
  input  logic [DATA_W-1:0] push_data,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fault,
  output logic              two_acc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wr0_en,
  output logic [IDX_W-1:0]  wr0_idx,
  output logic [DATA_W-1:0] wr0_data,
  output logic              wr1_en,
  output logic [IDX_W-1:0]  wr1_idx,
  output logic [DATA_W-1:0] wr1_data,
  output logic              pc_we,
  output logic [DATA_W-1:0] pc_out
);
  localparam logic [DATA_W-1:0] WORD_C   = DATA_W'(WORD_BYTES);
  localparam logic [DATA_W-1:0] SLOT_C   = DATA_W'(SLOT_BYTES);
  localparam logic [DATA_W-1:0] FRAME_C  = DATA_W'(SLOT_BYTES + WORD_BYTES);
  localparam logic [DATA_W-1:0] ALIGN_C  = DATA_W'(WORD_BYTES - 1);
  localparam logic [DATA_W-1:0] LONG_C   = DATA_W'(LONG_CALL_LEN);
  localparam logic [DATA_W-1:0] SHORT_C  = DATA_W'(SHORT_CALL_LEN);
  localparam logic [IDX_W-1:0]  FP_I     = IDX_W'(FP_IDX);
  localparam logic [IDX_W-1:0]  SP_I     = IDX_W'(SP_IDX);

  // return address saved by a call
  function automatic logic [DATA_W-1:0] f_link(input logic [OP_W-1:0] o,
                                               input logic [DATA_W-1:0] pc);
    return pc + ((o == OP_CALL_ABS) ? LONG_C : SHORT_C);
  endfunction

  // register whose alignment gates the operation
  function automatic logic [DATA_W-1:0] f_base(input logic [OP_W-1:0] o,
                                               input logic [DATA_W-1:0] fp,
                                               input logic [DATA_W-1:0] sp,
                                               input logic [DATA_W-1:0] stk);
    if (op_is_call(o))      return sp;
    else if (o == OP_RETURN) return fp;
    else                     return stk;
  endfunction

  // address of the first access
  function automatic logic [DATA_W-1:0] f_addr1(input logic [OP_W-1:0] o,
                                                input logic [DATA_W-1:0] fp,
                                                input logic [DATA_W-1:0] sp,
                                                input logic [DATA_W-1:0] stk);
    if (op_is_call(o))       return sp - SLOT_C;
    else if (o == OP_RETURN) return fp;
    else if (o == OP_PUSH)   return stk - WORD_C;
    else                     return stk;
  endfunction

  // address of the second access (calls and return only)
  function automatic logic [DATA_W-1:0] f_addr2(input logic [OP_W-1:0] o,
                                                input logic [DATA_W-1:0] fp,
                                                input logic [DATA_W-1:0] sp);
    if (op_is_call(o)) return sp - FRAME_C;
    else               return fp + WORD_C;
  endfunction

  // stack pointer after a frame is unwound
  function automatic logic [DATA_W-1:0] f_unwind(input logic [DATA_W-1:0] fp);
    return fp + FRAME_C;
  endfunction

  logic [OP_W-1:0]   op_q;
  logic [IDX_W-1:0]  sidx_q, didx_q;
  logic [DATA_W-1:0] tgt_q, pc_q, fp_q, sp_q, stk_q, dat_q, rd1_q, rd2_q;

  logic [DATA_W-1:0] base_now;
  assign base_now = f_base(op, fp_in, sp_in, stk_in);
  assign fault    = !op_known(op) || ((base_now & ALIGN_C) != '0);
  assign two_acc  = op_is_call(op) || (op == OP_RETURN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      sidx_q <= '0;
      didx_q <= '0;
      tgt_q  <= '0;
      pc_q   <= '0;
      fp_q   <= '0;
      sp_q   <= '0;
      stk_q  <= '0;
      dat_q  <= '0;
      rd1_q  <= '0;
      rd2_q  <= '0;
    end else begin
      if (accept) begin
        op_q   <= op;
        sidx_q <= stk_idx;
        didx_q <= dst_idx;
        tgt_q  <= target;
        pc_q   <= pc_in;
        fp_q   <= fp_in;
        sp_q   <= sp_in;
        stk_q  <= stk_in;
        dat_q  <= push_data;
      end
      if (st_acc1 && mem_ack) rd1_q <= mem_rdata;
      if (st_acc2 && mem_ack) rd2_q <= mem_rdata;
    end
  end

  logic is_call_q;
  assign is_call_q = op_is_call(op_q);

  // memory port
  always_comb begin
    mem_req   = st_acc1 || st_acc2;
    mem_we    = mem_req && (is_call_q || (op_q == OP_PUSH));
    mem_addr  = st_acc2 ? f_addr2(op_q, fp_q, sp_q) : f_addr1(op_q, fp_q, sp_q, stk_q);
    mem_wdata = '0;
    if (mem_we) begin
      if (op_q == OP_PUSH) mem_wdata = dat_q;
      else if (st_acc1)    mem_wdata = f_link(op_q, pc_q);
      else                 mem_wdata = fp_q;
    end
  end

  // write-back
  always_comb begin
    wr0_en   = 1'b0;
    wr0_idx  = '0;
    wr0_data = '0;
    wr1_en   = 1'b0;
    wr1_idx  = '0;
    wr1_data = '0;
    pc_we    = 1'b0;
    pc_out   = '0;
    if (st_wb) begin
      if (is_call_q) begin
        wr0_en   = 1'b1;
        wr0_idx  = FP_I;
        wr0_data = f_addr2(op_q, fp_q, sp_q);
        wr1_en   = 1'b1;
        wr1_idx  = SP_I;
        wr1_data = f_addr2(op_q, fp_q, sp_q);
        pc_we    = 1'b1;
        pc_out   = tgt_q;
      end else if (op_q == OP_RETURN) begin
        wr0_en   = 1'b1;
        wr0_idx  = FP_I;
        wr0_data = rd1_q;
        wr1_en   = 1'b1;
        wr1_idx  = SP_I;
        wr1_data = f_unwind(fp_q);
        pc_we    = 1'b1;
        pc_out   = rd2_q;
      end else if (op_q == OP_PUSH) begin
        wr1_en   = 1'b1;
        wr1_idx  = sidx_q;
        wr1_data = stk_q - WORD_C;
      end else begin
        wr0_en   = 1'b1;
        wr0_idx  = didx_q;
        wr0_data = rd1_q;
        wr1_en   = (didx_q != sidx_q);
        wr1_idx  = sidx_q;
        wr1_data = stk_q + WORD_C;
      end
    end
  end
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import frame_seq_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int IDX_W          = 4,
  parameter int FP_IDX         = 0,
  parameter int SP_IDX         = 1,
  parameter int WORD_BYTES     = 4,
  parameter int SLOT_BYTES     = 8,
  parameter int LONG_CALL_LEN  = 6,
  parameter int SHORT_CALL_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic [IDX_W-1:0]  stk_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [DATA_W-1:0] target,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] fp_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] stk_in,
  input  logic [DATA_W-1:0] push_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wr0_en,
  output logic [IDX_W-1:0]  wr0_idx,
  output logic [DATA_W-1:0] wr0_data,
  output logic              wr1_en,
  output logic [IDX_W-1:0]  wr1_idx,
  output logic [DATA_W-1:0] wr1_data,
  output logic              pc_we,
  output logic [DATA_W-1:0] pc_out,
  output logic              done,
  output logic              err
);
  // named internal events, observed by the checker
  logic accept, busy, fault, two_acc, st_acc1, st_acc2, st_wb;

  frame_seq_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .fault   (fault),
    .two_acc (two_acc),
    .mem_ack (mem_ack),
    .accept  (accept),
    .busy    (busy),
    .st_acc1 (st_acc1),
    .st_acc2 (st_acc2),
    .st_wb   (st_wb),
    .done    (done),
    .err     (err)
  );

  frame_seq_dpath #(
    .DATA_W         (DATA_W),
    .IDX_W          (IDX_W),
    .FP_IDX         (FP_IDX),
    .SP_IDX         (SP_IDX),
    .WORD_BYTES     (WORD_BYTES),
    .SLOT_BYTES     (SLOT_BYTES),
    .LONG_CALL_LEN  (LONG_CALL_LEN),
    .SHORT_CALL_LEN (SHORT_CALL_LEN)
  ) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .st_acc1   (st_acc1),
    .st_acc2   (st_acc2),
    .st_wb     (st_wb),
    .op        (op),
    .stk_idx   (stk_idx),
    .dst_idx   (dst_idx),
    .target    (target),
    .pc_in     (pc_in),
    .fp_in     (fp_in),
    .sp_in     (sp_in),
    .stk_in    (stk_in),
    .push_data (push_data),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .fault     (fault),
    .two_acc   (two_acc),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wr0_en    (wr0_en),
    .wr0_idx   (wr0_idx),
    .wr0_data  (wr0_data),
    .wr1_en    (wr1_en),
    .wr1_idx   (wr1_idx),
    .wr1_data  (wr1_data),
    .pc_we     (pc_we),
    .pc_out    (pc_out)
  );
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 4,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              busy,
  input logic              fault,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              wr0_en,
  input logic [IDX_W-1:0]  wr0_idx,
  input logic              wr1_en,
  input logic [IDX_W-1:0]  wr1_idx,
  input logic              pc_we,
  input logic              done,
  input logic              err
);
  localparam logic [DATA_W-1:0] ALIGN_C = DATA_W'(WORD_BYTES - 1);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !wr0_en && !wr1_en && !pc_we && !done); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R7
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr & ALIGN_C) == '0)); // R8
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fault |=> done && err && !mem_req); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> $past(wr0_en || wr1_en)); // R9
  AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en || wr1_en) |=> !(wr0_en || wr1_en) && done && !err); // R9
  AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(!wr0_en && !wr1_en && !pc_we)); // R8
  AST_PORTS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    wr0_en && wr1_en |-> wr0_idx != wr1_idx); // R6
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy); // R10
endmodule

bind stack_frame_seq frame_seq_chk #(
  .DATA_W     (DATA_W),
  .IDX_W      (IDX_W),
  .WORD_BYTES (WORD_BYTES)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .busy      (busy),
  .fault     (fault),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .wr0_en    (wr0_en),
  .wr0_idx   (wr0_idx),
  .wr1_en    (wr1_en),
  .wr1_idx   (wr1_idx),
  .pc_we     (pc_we),
  .done      (done),
  .err       (err)
);

// File: tb/stack_frame_seq_tb_top.sv
module stack_frame_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [3:0]  stk_idx, dst_idx;
  logic [31:0] target, pc_in, fp_in, sp_in, stk_in, push_data;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        wr0_en, wr1_en, pc_we, done, err;
  logic [3:0]  wr0_idx, wr1_idx;
  logic [31:0] wr0_data, wr1_data, pc_out;

  always #5 clk = ~clk;

  stack_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .stk_idx(stk_idx), .dst_idx(dst_idx),
    .target(target), .pc_in(pc_in), .fp_in(fp_in), .sp_in(sp_in), .stk_in(stk_in),
    .push_data(push_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
    .pc_we(pc_we), .pc_out(pc_out), .done(done), .err(err)
  );

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  logic [31:0] mem [int unsigned];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: acts just after each rising edge
  initial begin
    int cnt;
    cnt = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      #1;
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
      end
      if (mem_req && rst_n) begin
        if (cnt >= lat) begin
          mem_ack = 1'b1;
          if (mem_we) mem[mem_addr] = mem_wdata;
          else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        end else cnt++;
      end
    end
  end

  // observations of the last operation
  int          n_tx, req_cycles, wb_count, done_count, wb_cyc, done_cyc, late_activity;
  logic [31:0] tx_addr [4];
  logic [31:0] tx_wd   [4];
  logic        tx_we   [4];
  logic        o_w0e, o_w1e, o_pce, o_err;
  logic [3:0]  o_w0i, o_w1i;
  logic [31:0] o_w0d, o_w1d, o_pcv;

  task automatic run_op(input logic [2:0] o, input logic [3:0] si, input logic [3:0] di,
                        input logic [31:0] tg, input logic [31:0] pc, input logic [31:0] fp,
                        input logic [31:0] sp, input logic [31:0] stk, input logic [31:0] pd,
                        input bit poke);
    n_tx = 0; req_cycles = 0; wb_count = 0; done_count = 0; wb_cyc = -1; done_cyc = -1;
    late_activity = 0;
    o_w0e = 0; o_w1e = 0; o_pce = 0; o_err = 0;
    o_w0i = '0; o_w1i = '0; o_w0d = '0; o_w1d = '0; o_pcv = '0;
    @(negedge clk);
    op = o; stk_idx = si; dst_idx = di; target = tg; pc_in = pc;
    fp_in = fp; sp_in = sp; stk_in = stk; push_data = pd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 100; cyc++) begin
      if (mem_req) req_cycles++;
      if (mem_req && mem_ack && n_tx < 4) begin
        tx_addr[n_tx] = mem_addr; tx_wd[n_tx] = mem_wdata; tx_we[n_tx] = mem_we;
        n_tx++;
      end
      if (wr0_en || wr1_en || pc_we) begin
        wb_count++; wb_cyc = cyc;
        o_w0e = wr0_en; o_w0i = wr0_idx; o_w0d = wr0_data;
        o_w1e = wr1_en; o_w1i = wr1_idx; o_w1d = wr1_data;
        o_pce = pc_we;  o_pcv = pc_out;
      end
      if (poke && cyc == 1) begin
        start = 1'b1; op = 3'd3; stk_in = 32'h0000_3000; push_data = 32'hBADB_AD00;
      end else start = 1'b0;
      if (done) begin
        done_count++; done_cyc = cyc; o_err = err;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done || mem_req || wr0_en || wr1_en || pc_we) late_activity++;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; op = '0; stk_idx = '0; dst_idx = '0;
    target = '0; pc_in = '0; fp_in = '0; sp_in = '0; stk_in = '0; push_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "mem_req after reset", {31'b0, mem_req}, 32'd0);
    chk("R1", "done after reset", {31'b0, done}, 32'd0);
    chk("R1", "writes after reset", {29'b0, wr0_en, wr1_en, pc_we}, 32'd0);
  endtask

  task automatic t_call_abs;
    lat = 0;
    run_op(3'd0, 4'd0, 4'd0, 32'h0000_0800, 32'h0000_0400, 32'h0000_2000, 32'h0000_1000, 32'h0, 32'h0, 0);
    chk("R2", "access count", n_tx, 2);
    chk("R2", "first addr", tx_addr[0], 32'h0000_0FF8);
    chk("R2", "first data (pc+6)", tx_wd[0], 32'h0000_0406);
    chk("R2", "first is write", {31'b0, tx_we[0]}, 32'd1);
    chk("R2", "second addr", tx_addr[1], 32'h0000_0FF4);
    chk("R2", "second data (old fp)", tx_wd[1], 32'h0000_2000);
    chk("R2", "fp write", {o_w0e, 27'b0, o_w0i}, {1'b1, 27'b0, 4'd0});
    chk("R2", "fp value", o_w0d, 32'h0000_0FF4);
    chk("R2", "sp write", {o_w1e, 27'b0, o_w1i}, {1'b1, 27'b0, 4'd1});
    chk("R2", "sp value", o_w1d, 32'h0000_0FF4);
    chk("R2", "pc value", {31'b0, o_pce} + o_pcv, 32'h0000_0801);
    chk("R9", "single write-back cycle", wb_count, 1);
    chk("R9", "done one cycle after write-back", done_cyc, wb_cyc + 1);
    chk("R9", "no error", {31'b0, o_err}, 32'd0);
    chk("R9", "quiet after done", late_activity, 0);
  endtask

  task automatic t_return;
    lat = 1;
    run_op(3'd2, 4'd0, 4'd0, 32'h0, 32'h0, 32'h0000_0FF4, 32'h0000_0777, 32'h0, 32'h0, 0);
    chk("R4", "access count", n_tx, 2);
    chk("R4", "first addr", tx_addr[0], 32'h0000_0FF4);
    chk("R4", "second addr", tx_addr[1], 32'h0000_0FF8);
    chk("R4", "reads only", {30'b0, tx_we[0], tx_we[1]}, 32'd0);
    chk("R4", "fp restored", o_w0d, 32'h0000_2000);
    chk("R4", "sp unwound", o_w1d, 32'h0000_1000);
    chk("R4", "pc returned", o_pcv, 32'h0000_0406);
    chk("R4", "pc write enable", {31'b0, o_pce}, 32'd1);
  endtask

  task automatic t_call_reg;
    lat = 2;
    run_op(3'd1, 4'd0, 4'd0, 32'h0000_4000, 32'h0000_0200, 32'h0000_0F00, 32'h0000_0E00, 32'h0, 32'h0, 0);
    chk("R3", "return addr pc+2", tx_wd[0], 32'h0000_0202);
    chk("R3", "return addr location", tx_addr[0], 32'h0000_0DF8);
    chk("R3", "saved fp location", tx_addr[1], 32'h0000_0DF4);
    chk("R3", "pc to register value", o_pcv, 32'h0000_4000);
    chk("R7", "request cycles with 2 wait states", req_cycles, 6);
  endtask

  task automatic t_push_pop;
    lat = 0;
    run_op(3'd3, 4'd7, 4'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_5000, 32'hCAFE_F00D, 0);
    chk("R5", "push addr", tx_addr[0], 32'h0000_4FFC);
    chk("R5", "push data", tx_wd[0], 32'hCAFE_F00D);
    chk("R5", "stack reg write", {o_w1e, 27'b0, o_w1i}, {1'b1, 27'b0, 4'd7});
    chk("R5", "stack reg value", o_w1d, 32'h0000_4FFC);
    chk("R5", "no fp/pc write", {30'b0, o_w0e, o_pce}, 32'd0);
    lat = 3;
    run_op(3'd4, 4'd7, 4'd9, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_4FFC, 32'h0, 0);
    chk("R6", "pop addr", tx_addr[0], 32'h0000_4FFC);
    chk("R6", "dest write", {o_w0e, 27'b0, o_w0i}, {1'b1, 27'b0, 4'd9});
    chk("R6", "dest value", o_w0d, 32'hCAFE_F00D);
    chk("R6", "stack reg value", o_w1d, 32'h0000_5000);
    chk("R7", "request cycles with 3 wait states", req_cycles, 4);
    lat = 0;
    run_op(3'd4, 4'd5, 4'd5, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_0FF8, 32'h0, 0);
    chk("R6", "same reg: loaded value", o_w0d, 32'h0000_0406);
    chk("R6", "same reg: no increment write", {31'b0, o_w1e}, 32'd0);
  endtask

  task automatic t_faults;
    run_op(3'd0, 4'd0, 4'd0, 32'h0, 32'h0, 32'h0000_2000, 32'h0000_1002, 32'h0, 32'h0, 0);
    chk("R8", "misaligned sp: no access", n_tx + req_cycles, 0);
    chk("R8", "misaligned sp: err", {31'b0, o_err}, 32'd1);
    chk("R8", "misaligned sp: no write-back", wb_count, 0);
    chk("R8", "misaligned sp: done first cycle", done_cyc, 0);
    run_op(3'd2, 4'd0, 4'd0, 32'h0, 32'h0, 32'h0000_0FF5, 32'h0000_1000, 32'h0, 32'h0, 0);
    chk("R8", "misaligned fp: err", {31'b0, o_err}, 32'd1);
    chk("R8", "misaligned fp: no access", req_cycles, 0);
    run_op(3'd6, 4'd0, 4'd0, 32'h0, 32'h0, 32'h0000_2000, 32'h0000_1000, 32'h0000_1000, 32'h0, 0);
    chk("R11", "unassigned op: err", {31'b0, o_err}, 32'd1);
    chk("R11", "unassigned op: no access", req_cycles + wb_count, 0);
  endtask

  task automatic t_busy;
    lat = 1;
    mem[32'h0000_2FFC] = 32'h1234_5678;
    run_op(3'd0, 4'd0, 4'd0, 32'h0000_0900, 32'h0000_0100, 32'h0000_2200, 32'h0000_2100, 32'h0, 32'h0, 1);
    chk("R10", "only the call's accesses", n_tx, 2);
    chk("R10", "single done", done_count, 1);
    chk("R10", "nothing after done", late_activity, 0);
    chk("R10", "poked push left memory alone", mem[32'h0000_2FFC], 32'h1234_5678);
  endtask

  initial begin
    t_reset();
    t_call_abs();
    t_return();
    t_call_reg();
    t_push_pop();
    t_faults();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule